// File: doc/BRIEF.md
# Byte Bit Test-and-Modify Unit

This unit carries out one single-bit operation on a byte held in memory. A request names a base address, a signed 16-bit displacement, a bit position within the byte and one of four operations: set, invert, clear or test. The unit adds the sign-extended displacement to the base to form the byte address. It reads that byte over a request/ready memory port and reports in the zero flag whether the chosen bit was clear before the change. For set, invert and clear, it then writes the altered byte back to the same address.

A sequencer drives the unit with a one-cycle start pulse and the current flag word. It waits for the one-cycle done pulse and then takes the updated flag word. The read and the write-back of one request run as one uninterrupted sequence. No second request is accepted until the first has finished. The sequence of phases is idle, read, modify, write (skipped for test) and done.

Top module: `bitop_unit`

## Requirements
- R1: The byte address is `base_i` plus `disp_i` sign-extended to the address width, computed modulo 2^AW. It is presented on `mem_addr_o` for both the read and the write of a request.
- R2: Each accepted request issues exactly one read (`mem_req_o`=1, `mem_we_o`=0). The read completes on the first clock edge where `mem_ready_i` is 1. The read data is taken from `mem_rdata_i` on that edge.
- R3: After a request, flag bit 0 (Z) of `flags_o` is 1 if the selected bit of the byte read was 0, and 0 if it was 1.
- R4: Operation code 2'b00 writes back the byte with the selected bit forced to 1. Code 2'b01 writes it with the bit inverted. Code 2'b10 writes it with the bit forced to 0. No other bit of the byte changes.
- R5: Operation code 2'b11 (test) issues no write. The unit goes from modify straight to done.
- R6: Every bit of `flags_o` other than bit 0 equals the matching bit of `flags_i` sampled on the start edge. `flags_o` changes only on the edge that ends the modify phase.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. It changes neither the address, the operation, the bit index nor the flags of the request in progress.
- R8: While a request waits on `mem_ready_i`, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady. `done_o` is a single-cycle pulse, after which the unit is idle.
- R9: After reset the unit is idle: `busy_o`, `done_o`, `mem_req_o` and `mem_we_o` are 0, and `flags_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| op_i | input | 2 | Operation: 00 set, 01 invert, 10 clear, 11 test |
| base_i | input | AW | Base address |
| disp_i | input | 16 | Signed displacement |
| bit_idx_i | input | 3 | Bit position within the byte |
| flags_i | input | FW | Flag word current at the request |
| flags_o | output | FW | Updated flag word, Z in bit 0 |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_ready_i | input | 1 | Memory completes the current access |

## Verification
The start edge puts the unit in the read phase, so `mem_req_o` is seen one cycle after the start is sampled. With a zero-wait memory the read ends one edge later. The modify edge follows, and it updates `flags_o`. The write request appears on the next cycle for set, invert and clear, and `done_o` one cycle after the write handshake. For test, `done_o` comes directly after modify. The bench advances a phase-based reference model on each rising edge from the handshakes it grants. It compares every output on the falling edge, so each result is checked in exactly the cycle it is due. The memory latency is varied from zero to three wait cycles so that R8's hold behaviour is covered.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_SET = 2'b00,
        BOP_INV = 2'b01,
        BOP_CLR = 2'b10,
        BOP_TST = 2'b11
    } bop_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_MODIFY = 3'd2,
        ST_WRITE  = 3'd3,
        ST_DONE   = 3'd4
    } bstate_e;

endpackage

// File: rtl/bitop_agen.sv
module bitop_agen #(
    parameter int AW    = 32,
    parameter int DISPW = 16
) (
    input  logic [AW-1:0]    base_i,
    input  logic [DISPW-1:0] disp_i,
    output logic [AW-1:0]    addr_o
);
    localparam int EXTW = AW - DISPW;

    logic [AW-1:0] disp_ext;

    generate
        if (EXTW > 0) begin : g_ext
            assign disp_ext = {{EXTW{disp_i[DISPW-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext = disp_i[AW-1:0];
        end
    endgenerate

    // modulo-2^AW sum; carry out discarded on purpose
    assign addr_o = base_i + disp_ext;

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = $clog2(DW)
) (
    input  bop_e          op_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] byte_i,
    output logic [DW-1:0] byte_o,
    output logic          was_zero_o
);
    logic [DW-1:0] mask;

    generate
        for (genvar g = 0; g < DW; g++) begin : g_mask
            assign mask[g] = (idx_i == IW'(g));
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            BOP_SET: byte_o = byte_i | mask;
            BOP_INV: byte_o = byte_i ^ mask;
            BOP_CLR: byte_o = byte_i & ~mask;
            default: byte_o = byte_i;
        endcase
        was_zero_o = ((byte_i & mask) == '0);
    end

    // R4: only the selected bit may differ between input and output byte
    always_comb begin
        assert ($countones(byte_o ^ byte_i) <= 1)
            else $error("p_single_bit_r4");
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int AW    = 32,
    parameter int FW    = 8,
    parameter int ZPOS  = 0,
    parameter int DISPW = 16,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [AW-1:0]     base_i,
    input  logic [DISPW-1:0]  disp_i,
    input  logic [2:0]        bit_idx_i,
    input  logic [FW-1:0]     flags_i,
    output logic [FW-1:0]     flags_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic              mem_ready_i
);
    localparam int IW = $clog2(DW);

    typedef struct packed {
        bstate_e       state;
        logic [AW-1:0] addr;
        bop_e          op;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic [FW-1:0] flags_in;
        logic [FW-1:0] flags_out;
    } regs_t;

    regs_t         r_q, r_d;
    logic [AW-1:0] agen_addr;
    logic [DW-1:0] alu_byte;
    logic          alu_zero;

    bitop_agen #(.AW(AW), .DISPW(DISPW)) u_agen (
        .base_i (base_i),
        .disp_i (disp_i),
        .addr_o (agen_addr)
    );

    bitop_alu #(.DW(DW), .IW(IW)) u_alu (
        .op_i       (r_q.op),
        .idx_i      (r_q.idx),
        .byte_i     (r_q.data),
        .byte_o     (alu_byte),
        .was_zero_o (alu_zero)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr     = agen_addr;
                    r_d.op       = bop_e'(op_i);
                    r_d.idx      = bit_idx_i[IW-1:0];
                    r_d.flags_in = flags_i;
                    r_d.state    = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready_i) begin
                    r_d.data  = mem_rdata_i;
                    r_d.state = ST_MODIFY;
                end
            end
            ST_MODIFY: begin
                r_d.data            = alu_byte;
                r_d.flags_out       = r_q.flags_in;
                r_d.flags_out[ZPOS] = alu_zero;
                r_d.state           = (r_q.op == BOP_TST) ? ST_DONE : ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready_i) begin
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: BOP_SET, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign flags_o     = r_q.flags_out;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = (r_q.state == ST_DONE);
    assign mem_req_o   = (r_q.state == ST_READ) || (r_q.state == ST_WRITE);
    assign mem_we_o    = (r_q.state == ST_WRITE);
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.data;

    // R5: a write is never issued for a test request
    p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (r_q.op != BOP_TST));

    // R8: a waiting access holds its request, direction, address and data
    p_hold_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R8: done lasts one cycle and leaves the unit idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R6: flag output moves only on the edge leaving modify
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_MODIFY) |=> $stable(flags_o));

    // R7: a start while busy leaves the captured address alone
    p_ignore_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mem_addr_o));

    // R2: a read ending is followed by modify, with no request that cycle
    p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_ready_i) |=> !mem_req_o);

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = '0;
    logic [AW-1:0] base_i = '0;
    logic [15:0]   disp_i = '0;
    logic [2:0]    bit_idx_i = '0;
    logic [FW-1:0] flags_i = '0;
    logic [FW-1:0] flags_o;
    logic          busy_o, done_o, mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_wdata_o;
    logic [7:0]    mem_rdata_i = '0;
    logic          mem_ready_i = 1'b0;

    bitop_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int lat = 0;
    int wait_cnt = 0;

    logic [7:0] mem [int unsigned];

    // reference model state
    int            ph = 0;            // 0 idle 1 read 2 modify 3 write 4 done
    logic [AW-1:0] m_addr = '0;
    int            m_op = 0;
    int            m_idx = 0;
    logic [7:0]    m_byte = '0;
    logic [7:0]    m_new = '0;
    logic [FW-1:0] m_fin = '0;
    logic [FW-1:0] m_flags = '0;
    int            writes_seen = 0;
    int            reads_seen = 0;

    function automatic logic [7:0] rd(logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // model advance and memory side effects on the rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = 0;
            m_flags = '0;
        end else begin
            case (ph)
                0: if (start_i) begin
                    m_addr = base_i + {{16{disp_i[15]}}, disp_i};
                    m_op = op_i;
                    m_idx = bit_idx_i;
                    m_fin = flags_i;
                    ph = 1;
                end
                1: if (mem_ready_i) begin
                    m_byte = rd(m_addr);
                    reads_seen++;
                    ph = 2;
                end
                2: begin
                    case (m_op)
                        0: m_new = m_byte | (8'h1 << m_idx);
                        1: m_new = m_byte ^ (8'h1 << m_idx);
                        2: m_new = m_byte & ~(8'h1 << m_idx);
                        default: m_new = m_byte;
                    endcase
                    m_flags = m_fin;
                    m_flags[0] = ~m_byte[m_idx];
                    ph = (m_op == 3) ? 4 : 3;
                end
                3: if (mem_ready_i) ph = 4;
                default: ph = 0;
            endcase
            if (mem_req_o && mem_ready_i && mem_we_o) begin
                mem[mem_addr_o] = mem_wdata_o;
                writes_seen++;
            end
        end
    end

    // compare on the falling edge, then drive the memory response
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy_o == (ph != 0), "R8 busy", busy_o, ph != 0);
            chk(done_o == (ph == 4), "R8 done", done_o, ph == 4);
            chk(mem_req_o == (ph == 1 || ph == 3), "R2 req", mem_req_o, ph == 1 || ph == 3);
            chk(mem_we_o == (ph == 3), "R5 we", mem_we_o, ph == 3);
            chk(flags_o[0] == m_flags[0], "R3 zflag", flags_o[0], m_flags[0]);
            chk(flags_o[FW-1:1] == m_flags[FW-1:1], "R6 flags", flags_o, m_flags);
            if (ph == 1 || ph == 3)
                chk(mem_addr_o == m_addr, "R1 addr", mem_addr_o, m_addr);
            if (ph == 3)
                chk(mem_wdata_o == m_new, "R4 wdata", mem_wdata_o, m_new);
        end
        if (mem_req_o && !mem_ready_i && wait_cnt >= lat) begin
            mem_ready_i = 1'b1;
            mem_rdata_i = mem_we_o ? 8'hxx : rd(mem_addr_o);
            wait_cnt = 0;
        end else begin
            if (mem_req_o && !mem_ready_i) wait_cnt++;
            mem_ready_i = 1'b0;
        end
    end

    task automatic run_op(input int op, input logic [AW-1:0] b, input logic [15:0] d,
                          input int idx, input logic [FW-1:0] fl);
        @(negedge clk);
        start_i = 1'b1; op_i = op[1:0]; base_i = b; disp_i = d;
        bit_idx_i = idx[2:0]; flags_i = fl;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    task automatic run_and_check(input int op, input logic [AW-1:0] b, input logic [15:0] d,
                                 input int idx, input logic [FW-1:0] fl, input logic [7:0] init);
        logic [AW-1:0] a;
        logic [7:0] expb;
        int w0;
        a = b + {{16{d[15]}}, d};
        mem[a] = init;
        case (op)
            0: expb = init | (8'h1 << idx);
            1: expb = init ^ (8'h1 << idx);
            2: expb = init & ~(8'h1 << idx);
            default: expb = init;
        endcase
        w0 = writes_seen;
        run_op(op, b, d, idx, fl);
        chk(rd(a) == expb, "R4 memory byte", rd(a), expb);
        chk((writes_seen - w0) == ((op == 3) ? 0 : 1), "R5 write count", writes_seen - w0, (op == 3) ? 0 : 1);
        chk(flags_o[0] == ~init[idx], "R3 z after op", flags_o[0], ~init[idx]);
        chk(flags_o[FW-1:1] == fl[FW-1:1], "R6 other flags", flags_o, fl);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy_o && !done_o && !mem_req_o && !mem_we_o, "R9 idle outputs", {busy_o, done_o, mem_req_o, mem_we_o}, 0);
        chk(flags_o == '0, "R9 flags", flags_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int op = 0; op < 4; op++) begin
                r0 = reads_seen;
                run_and_check(op, 32'h0000_2000 + l * 64, 16'h0010, (op * 3 + l) % 8, 8'hF6, 8'hA5);
                chk(reads_seen - r0 == 1, "R2 one read", reads_seen - r0, 1);
                run_and_check(op, 32'h0000_3000, 16'hFFF0 - l, (op + 5) % 8, 8'h19, 8'h5A);
            end
        end
        // R1 wrap and negative displacement
        lat = 1;
        run_and_check(0, 32'hFFFF_FFF0, 16'h0020, 7, 8'hFE, 8'h00);
        run_and_check(2, 32'h0000_0008, 16'hFFF8, 0, 8'h01, 8'hFF);
        run_and_check(1, 32'h1234_0000, 16'h7FFF, 4, 8'h80, 8'h10);
        // R7 start while busy is ignored
        lat = 3;
        mem[32'h4004] = 8'h00;
        mem[32'h5000] = 8'hFF;
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd0; base_i = 32'h4000; disp_i = 16'h4;
        bit_idx_i = 3'd2; flags_i = 8'h40;
        @(negedge clk);
        op_i = 2'd2; base_i = 32'h5000; disp_i = 16'h0; bit_idx_i = 3'd7; flags_i = 8'h82;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        chk(rd(32'h4004) == 8'h04, "R7 first request kept", rd(32'h4004), 8'h04);
        chk(rd(32'h5000) == 8'hFF, "R7 busy start ignored", rd(32'h5000), 8'hFF);
        chk(flags_o == 8'h41, "R7 flags from first request", flags_o, 8'h41);
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o, "R8 idle after done", {busy_o, done_o}, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule